// File: doc/BRIEF.md
# Reset Source and Boot-Map Controller

This block gathers every reason a small 8-bit microcontroller may need to restart and turns them into a single stretched core reset. The sources are a synchronous power-on indication, an external reset pin, a software-triggered restart and a supply-drop comparator. It also holds the two-bit code-map field. That field decides whether the lowest 8 kB of code space shows the boot block or the first 8 kB of user code. Each reset source leaves a different value in it.

Software sees two register write targets, selected by `wr_sel_i`. The map register (select 0) has the soft-restart bit at bit 1 and the bank bit at bit 0. The power register (select 1) is write-1-to-clear: bit 0 clears the power-up flag and bit 1 clears the supply-drop flag.

A 0-to-1 change of the soft-restart bit restarts the core and requests a program-counter reload to 0000H. It leaves state that survives soft restarts untouched: `hard_rst_o` stays low, so watchdog-control bit 2 and RAM are kept. A supply drop either raises a sticky interrupt flag or acts as a hard reset, chosen by `bod_rst_mode_i`.

Top module: `rstmap_ctrl`

## Requirements
- R1: While `por_i` is high, the map field reads 00 and `boot_blk_o` is 1. In the same condition `pof_o`, `core_rst_o` and `hard_rst_o` are 1 and `bod_irq_o` is 0.
- R2: A high level on `rst_pin_i`, after a two-flop synchronizer, has the same effect as power-on: map field 00 and both resets asserted. The one exception is that `pof_o` is not set.
- R3: `boot_blk_o` is 1 exactly when the map field is 00. Map field bit 1 is the soft-restart bit and bit 0 is the bank bit, written from `wr_data_i[1:0]` with `wr_sel_i`=0.
- R4: A map write that takes the soft-restart bit from 0 to 1 does three things. It sets the map field to 10, whatever `wr_data_i[0]` holds. It pulses `pc_reload_o` for one cycle in the cycle after the write. It asserts `core_rst_o` but not `hard_rst_o`.
- R5: A map write with bit 1 set while the field's bit 1 is already 1 causes no restart and no reload. It only stores `wr_data_i[1:0]`.
- R6: `pof_o` is set only by `por_i`. It is cleared by a power-register write with bit 0 = 1, and no reset from the pin, software or supply drop sets it again.
- R7: With `bod_rst_mode_i`=0, a rising edge of the synchronized `bod_low_i` sets `bod_irq_o` without any reset. The flag holds until a power-register write with bit 1 = 1.
- R8: With `bod_rst_mode_i`=1, a synchronized high `bod_low_i` acts as a hard reset: map field 00, `core_rst_o` and `hard_rst_o` high, and no flag set.
- R9: `core_rst_o` stays high for 16 cycles after the last cycle a reset request is seen. After a pin release, it falls in the 18th cycle from the input change.
- R10: When a hard request and a soft-restart write fall in the same cycle, the map field becomes 00 and `pc_reload_o` stays low.
- R11: Register writes made while `core_rst_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on indication, synchronous, active high |
| rst_pin_i | input | 1 | Raw external reset pin, active high |
| bod_low_i | input | 1 | Raw comparator level, 1 = supply below threshold |
| bod_rst_mode_i | input | 1 | 0 = supply drop raises a flag, 1 = supply drop resets |
| wr_en_i | input | 1 | One-cycle register write strobe |
| wr_sel_i | input | 1 | 0 = map register, 1 = power register |
| wr_data_i | input | DATA_W | Write data |
| core_rst_o | output | 1 | Stretched core reset |
| hard_rst_o | output | 1 | Reset for state kept across soft restarts |
| pc_reload_o | output | 1 | One-cycle program-counter reload request |
| map_o | output | 2 | Map field {soft-restart bit, bank bit} |
| boot_blk_o | output | 1 | 1 = low 8 kB shows the boot block |
| pof_o | output | 1 | Power-up flag |
| bod_irq_o | output | 1 | Sticky supply-drop interrupt flag |

## Verification
The assertions assume that `por_i` is already synchronous to `clk`, so they are disabled while it is high. They also assume `bod_rst_mode_i` is quasi-static and that a write strobe lasts one cycle. The stimulus honours this: the mode changes only while the comparator input is low, each write is a single-cycle pulse driven on the falling edge, and pin and comparator levels are held for several cycles. Writes are placed both inside a stretch window and in the exact cycle in which a synchronized pin request arrives, so the gating and priority properties see real traffic.

// File: rtl/rstmap_pkg.sv
package rstmap_pkg;
   // map field encodings (bit 1 soft-restart bit, bit 0 bank bit)
   localparam logic [1:0] MAP_BOOT = 2'b00;
   localparam logic [1:0] MAP_USER = 2'b10;

   localparam int MAP_SWR_BIT  = 1;
   localparam int MAP_BANK_BIT = 0;
   localparam int PWR_POF_BIT  = 0;
   localparam int PWR_BOD_BIT  = 1;

   typedef enum logic {
      SEL_MAP = 1'b0,
      SEL_PWR = 1'b1
   } wsel_e;
endpackage

// File: rtl/rstmap_sync.sv
module rstmap_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic por,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstmap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (por)
            chain_q[s] <= RST_VAL;
         else if (s == 0)
            chain_q[s] <= d;
         else
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rstmap_stretch.sv
module rstmap_stretch #(
   parameter int STRETCH = 16
) (
   input  logic clk,
   input  logic por,
   input  logic hard_req,
   input  logic soft_req,
   output logic core_rst,
   output logic hard_rst
);
   localparam int CNT_W = $clog2(STRETCH + 1);
   localparam int RUN_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);

   if (STRETCH < 2) begin : g_bad_stretch
      $error("rstmap_stretch: STRETCH must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             hard_q;

   always_ff @(posedge clk) begin
      if (por || hard_req) begin
         cnt_q  <= LOAD;
         hard_q <= 1'b1;
      end else if (soft_req) begin
         cnt_q  <= LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1))
            hard_q <= 1'b0;
      end
   end

   assign core_rst = (cnt_q != '0);
   assign hard_rst = hard_q;

   // length of the current high run of core_rst, saturating
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (por)
         run_q <= '0;
      else if (!core_rst)
         run_q <= '0;
      else if (run_q != '1)
         run_q <= run_q + RUN_W'(1);
   end

   a_r9_min_stretch: assert property (@(posedge clk) disable iff (por)
      $fell(core_rst) |-> run_q >= RUN_W'(STRETCH));

   a_r2_hard_takes_effect: assert property (@(posedge clk) disable iff (por)
      hard_req |=> core_rst && hard_rst);

   a_r4_soft_no_hard: assert property (@(posedge clk) disable iff (por)
      soft_req && !hard_req && !hard_rst |=> core_rst && !hard_rst);
endmodule

// File: rtl/rstmap_regs.sv
module rstmap_regs
   import rstmap_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              por,
   input  logic              hard_req,
   input  logic              wr_ok,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bod_rise,
   input  logic              bod_mode,
   output logic [1:0]        map_q,
   output logic              pof_q,
   output logic              bod_flag_q,
   output logic              sw_fire,
   output logic              pc_reload_q
);
   if (DATA_W < 2) begin : g_bad_width
      $error("rstmap_regs: DATA_W must be at least 2");
   end

   if (DATA_W > 2) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:2];
   end

   logic map_wr;
   logic pwr_wr;

   assign map_wr  = wr_ok && (wr_sel == SEL_MAP);
   assign pwr_wr  = wr_ok && (wr_sel == SEL_PWR);
   assign sw_fire = map_wr && wr_data[MAP_SWR_BIT] && !map_q[MAP_SWR_BIT] && !hard_req;

   always_ff @(posedge clk) begin
      if (por || hard_req)
         map_q <= MAP_BOOT;
      else if (sw_fire)
         map_q <= MAP_USER;
      else if (map_wr)
         map_q <= {wr_data[MAP_SWR_BIT], wr_data[MAP_BANK_BIT]};
   end

   always_ff @(posedge clk) begin
      if (por)
         pof_q <= 1'b1;
      else if (pwr_wr && wr_data[PWR_POF_BIT])
         pof_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (por)
         bod_flag_q <= 1'b0;
      else if (bod_rise && !bod_mode)
         bod_flag_q <= 1'b1;
      else if (pwr_wr && wr_data[PWR_BOD_BIT])
         bod_flag_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (por)
         pc_reload_q <= 1'b0;
      else
         pc_reload_q <= sw_fire;
   end

   a_r4_soft_sets_user: assert property (@(posedge clk) disable iff (por)
      sw_fire |=> map_q == MAP_USER && pc_reload_q);

   a_r5_no_refire: assert property (@(posedge clk) disable iff (por)
      map_wr && map_q[MAP_SWR_BIT] |=> !pc_reload_q);

   a_r10_hard_wins: assert property (@(posedge clk) disable iff (por)
      hard_req && map_wr |=> map_q == MAP_BOOT && !pc_reload_q);

   a_r6_pof_never_rises: assert property (@(posedge clk) disable iff (por)
      !$rose(pof_q));

   a_r7_flag_sets: assert property (@(posedge clk) disable iff (por)
      bod_rise && !bod_mode |=> bod_flag_q);
endmodule

// File: rtl/rstmap_ctrl.sv
module rstmap_ctrl
   import rstmap_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STRETCH_CYC = 16,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              por_i,
   input  logic              rst_pin_i,
   input  logic              bod_low_i,
   input  logic              bod_rst_mode_i,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              core_rst_o,
   output logic              hard_rst_o,
   output logic              pc_reload_o,
   output logic [1:0]        map_o,
   output logic              boot_blk_o,
   output logic              pof_o,
   output logic              bod_irq_o
);
   logic pin_s;
   logic bod_s;
   logic bod_prev_q;
   logic bod_rise;
   logic hard_req;
   logic soft_req;
   logic wr_ok;

   rstmap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
      .clk (clk),
      .por (por_i),
      .d   (rst_pin_i),
      .q   (pin_s)
   );

   rstmap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bod_sync (
      .clk (clk),
      .por (por_i),
      .d   (bod_low_i),
      .q   (bod_s)
   );

   always_ff @(posedge clk) begin
      if (por_i)
         bod_prev_q <= 1'b0;
      else
         bod_prev_q <= bod_s;
   end

   assign bod_rise = bod_s && !bod_prev_q;
   assign hard_req = pin_s || (bod_s && bod_rst_mode_i);
   assign wr_ok    = wr_en_i && !core_rst_o;

   rstmap_stretch #(.STRETCH(STRETCH_CYC)) u_stretch (
      .clk      (clk),
      .por      (por_i),
      .hard_req (hard_req),
      .soft_req (soft_req),
      .core_rst (core_rst_o),
      .hard_rst (hard_rst_o)
   );

   rstmap_regs #(.DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .por         (por_i),
      .hard_req    (hard_req),
      .wr_ok       (wr_ok),
      .wr_sel      (wr_sel_i),
      .wr_data     (wr_data_i),
      .bod_rise    (bod_rise),
      .bod_mode    (bod_rst_mode_i),
      .map_q       (map_o),
      .pof_q       (pof_o),
      .bod_flag_q  (bod_irq_o),
      .sw_fire     (soft_req),
      .pc_reload_q (pc_reload_o)
   );

   assign boot_blk_o = (map_o == MAP_BOOT);

   a_r11_writes_blocked: assert property (@(posedge clk) disable iff (por_i)
      wr_en_i && core_rst_o && !hard_req |=> $stable(map_o) && !pc_reload_o);

   a_r8_bod_resets: assert property (@(posedge clk) disable iff (por_i)
      bod_s && bod_rst_mode_i |=> hard_rst_o && map_o == MAP_BOOT);

   a_r8_no_flag_in_reset_mode: assert property (@(posedge clk) disable iff (por_i)
      bod_rst_mode_i && !bod_irq_o |=> !bod_irq_o);
endmodule

// File: tb/rstmap_ctrl_test.sv
`timescale 1ns/1ps
module rstmap_ctrl_test;
   logic       clk = 1'b0;
   logic       por_i = 1'b1;
   logic       rst_pin_i = 1'b0;
   logic       bod_low_i = 1'b0;
   logic       bod_rst_mode_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic       wr_sel_i = 1'b0;
   logic [7:0] wr_data_i = 8'h00;
   logic       core_rst_o, hard_rst_o, pc_reload_o, boot_blk_o, pof_o, bod_irq_o;
   logic [1:0] map_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   rstmap_ctrl uut (
      .clk            (clk),
      .por_i          (por_i),
      .rst_pin_i      (rst_pin_i),
      .bod_low_i      (bod_low_i),
      .bod_rst_mode_i (bod_rst_mode_i),
      .wr_en_i        (wr_en_i),
      .wr_sel_i       (wr_sel_i),
      .wr_data_i      (wr_data_i),
      .core_rst_o     (core_rst_o),
      .hard_rst_o     (hard_rst_o),
      .pc_reload_o    (pc_reload_o),
      .map_o          (map_o),
      .boot_blk_o     (boot_blk_o),
      .pof_o          (pof_o),
      .bod_irq_o      (bod_irq_o)
   );

   // {sel, data[7:0], expected map, expected reload, expected pof}
   localparam logic [12:0] VEC [0:6] = '{
      {1'b0, 8'h01, 2'b01, 1'b0, 1'b1},  // R3 bank bit only
      {1'b0, 8'h03, 2'b10, 1'b1, 1'b1},  // R4 0->1 restart, bank forced 0
      {1'b0, 8'h03, 2'b11, 1'b0, 1'b1},  // R5 already 1: store only
      {1'b0, 8'h02, 2'b10, 1'b0, 1'b1},  // R5
      {1'b0, 8'h00, 2'b00, 1'b0, 1'b1},  // R3 back to boot map
      {1'b0, 8'hFE, 2'b10, 1'b1, 1'b1},  // R4 upper bits ignored
      {1'b1, 8'h01, 2'b10, 1'b0, 1'b0}   // R6 clear power-up flag
   };

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] data);
      wr_sel_i  = sel;
      wr_data_i = data;
      wr_en_i   = 1'b1;
      step(1);
      wr_en_i   = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(4);
      // R1 reset state
      chk("R1 map", {6'd0, map_o}, 8'h00);
      chk("R1 boot_blk", {7'd0, boot_blk_o}, 8'h01);
      chk("R1 pof", {7'd0, pof_o}, 8'h01);
      chk("R1 core_rst", {7'd0, core_rst_o}, 8'h01);
      chk("R1 hard_rst", {7'd0, hard_rst_o}, 8'h01);
      chk("R1 bod_irq", {7'd0, bod_irq_o}, 8'h00);
      por_i = 1'b0;
      step(5);
      // R11 write inside the stretch window is ignored
      wr(1'b0, 8'h02);
      chk("R11 reload", {7'd0, pc_reload_o}, 8'h00);
      step(9);
      // 15 edges after release
      chk("R9 por stretch high", {7'd0, core_rst_o}, 8'h01);
      step(2);
      chk("R9 por stretch low", {7'd0, core_rst_o}, 8'h00);
      chk("R11 map unchanged", {6'd0, map_o}, 8'h00);

      // vector table
      for (int i = 0; i < 7; i++) begin
         wr(VEC[i][12], VEC[i][11:4]);
         chk("R3/R4/R5 map", {6'd0, map_o}, {6'd0, VEC[i][3:2]});
         chk("R4/R5 reload", {7'd0, pc_reload_o}, {7'd0, VEC[i][1]});
         chk("R4 core_rst", {7'd0, core_rst_o}, {7'd0, VEC[i][1]});
         chk("R4 no hard_rst", {7'd0, hard_rst_o}, 8'h00);
         chk("R6 pof", {7'd0, pof_o}, {7'd0, VEC[i][0]});
         chk("R3 boot_blk", {7'd0, boot_blk_o}, {7'd0, (VEC[i][3:2] == 2'b00)});
         step(20);
      end

      // R2 pin reset
      rst_pin_i = 1'b1;
      step(4);
      chk("R2 map", {6'd0, map_o}, 8'h00);
      chk("R2 core_rst", {7'd0, core_rst_o}, 8'h01);
      chk("R2 hard_rst", {7'd0, hard_rst_o}, 8'h01);
      chk("R2 boot_blk", {7'd0, boot_blk_o}, 8'h01);
      chk("R6 pin leaves pof", {7'd0, pof_o}, 8'h00);
      rst_pin_i = 1'b0;
      step(17);
      chk("R9 pin stretch high", {7'd0, core_rst_o}, 8'h01);
      step(2);
      chk("R9 pin stretch low", {7'd0, core_rst_o}, 8'h00);
      chk("R9 hard released", {7'd0, hard_rst_o}, 8'h00);

      // R10 coincidence: write lands in the cycle the request arrives
      rst_pin_i = 1'b1;
      step(2);
      wr(1'b0, 8'h02);
      chk("R10 map", {6'd0, map_o}, 8'h00);
      chk("R10 reload", {7'd0, pc_reload_o}, 8'h00);
      chk("R10 hard_rst", {7'd0, hard_rst_o}, 8'h01);
      rst_pin_i = 1'b0;
      step(25);
      chk("R10 released", {7'd0, core_rst_o}, 8'h00);

      wr(1'b0, 8'h02);
      step(20);
      chk("R4 map user", {6'd0, map_o}, 8'h02);

      // R7 supply drop as interrupt
      bod_low_i = 1'b1;
      step(4);
      chk("R7 flag set", {7'd0, bod_irq_o}, 8'h01);
      chk("R7 no reset", {7'd0, core_rst_o}, 8'h00);
      chk("R7 map kept", {6'd0, map_o}, 8'h02);
      wr(1'b1, 8'h02);
      chk("R7 flag cleared", {7'd0, bod_irq_o}, 8'h00);
      step(3);
      chk("R7 stays clear", {7'd0, bod_irq_o}, 8'h00);
      bod_low_i = 1'b0;
      step(4);

      // R8 supply drop as reset
      bod_rst_mode_i = 1'b1;
      step(1);
      bod_low_i = 1'b1;
      step(4);
      chk("R8 core_rst", {7'd0, core_rst_o}, 8'h01);
      chk("R8 hard_rst", {7'd0, hard_rst_o}, 8'h01);
      chk("R8 map", {6'd0, map_o}, 8'h00);
      chk("R8 no flag", {7'd0, bod_irq_o}, 8'h00);
      bod_low_i = 1'b0;
      step(25);
      chk("R8 released", {7'd0, core_rst_o}, 8'h00);
      chk("R6 pof still clear", {7'd0, pof_o}, 8'h00);
      bod_rst_mode_i = 1'b0;

      // R6 only power-on sets the flag again
      por_i = 1'b1;
      step(2);
      chk("R6 pof set by por", {7'd0, pof_o}, 8'h01);
      por_i = 1'b0;
      step(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule